// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a direct-mapped data cache placed between a processor-side request port and a next-level memory port. Each line holds a tag, a valid flag, a dirty flag and one or more data words. A request whose tag matches a valid line completes in the cycle it is presented, with no memory traffic. The line is picked by the low-order bits of the block address. The tag is the remaining high-order bits.

On a miss the requester is stalled. A one-miss controller first copies a dirty victim line to memory, one word per beat. It then fetches the whole new block, installs it with the new tag and a clear dirty flag, and returns to idle. The requester holds its request throughout. That request now matches and completes as an ordinary hit. A store that missed is therefore merged only into a fully fetched line, and that merge marks the line dirty. Stores never write memory directly. Memory sees only whole dirty lines when they are evicted.

The default geometry uses 32-bit byte addresses, 32-bit words, 4 words per line and 64 lines. The same module also elaborates with one-word lines.

Top module: `dcache_wb`

## Requirements
- R1: With default parameters, byte-address bits 3:2 select the word, bits 9:4 select the line and bits 31:10 form the tag. Byte address 1200 uses line 11. It therefore conflicts with 176 and 2224 but not with 1216, and an eviction of its line writes back addresses 1200, 1204, 1208 and 1212.
- R2: After reset no line is valid, so the first request to any line misses (cpu_ready low in its first cycle). With no request pending, cpu_ready and mem_req are low.
- R3: A request that matches a valid line raises cpu_ready in the same cycle it is presented, with mem_req low. For a read, cpu_rvalid is high and cpu_rdata carries the current value of the addressed word.
- R4: A store that hits updates only the cached word and marks the line dirty. No memory beat occurs.
- R5: When a miss replaces a valid dirty line, the controller writes all words of the old line (mem_we=1) at the old line's addresses, in ascending order, before its first read beat. The data written equals the latest value stored to each word.
- R6: When a miss replaces an invalid or clean line, no write beat occurs.
- R7: A miss fetches the whole block with read beats (mem_we=0) in ascending word order from the line base, installs it, and then completes the held request. Unrequested words of the line return the memory contents.
- R8: A store that misses first fetches the complete block, then merges the store word. The line is then dirty, so its later eviction writes back the merged word together with the fetched words.
- R9: Memory transfers move one word per beat. mem_req, mem_we, mem_addr and mem_wdata stay stable until a cycle with mem_ack high completes the beat.
- R10: Only one miss is handled at a time. From the cycle a miss is detected until its fill completes, cpu_ready stays low and the requester must hold its request.
- R11: With 8 one-word lines, the word addresses 22, 26, 22, 26, 16, 3, 16, 18, 16 (byte address = 4 × word) give miss, miss, hit, hit, miss, miss, hit, miss, hit. Afterwards, words 16, 18, 3 and 22 all hit, which shows that lines 0, 2, 3 and 6 hold tags 10, 10, 00 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request pending; held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | WORD_W | Store data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rvalid | output | 1 | Load data valid this cycle |
| cpu_rdata | output | WORD_W | Load data |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | 1 = write-back beat, 0 = fill beat |
| mem_addr | output | ADDR_W | Word-aligned beat address |
| mem_wdata | output | WORD_W | Write-back data |
| mem_ack | input | 1 | Beat completes at this edge |
| mem_rdata | input | WORD_W | Fill data, valid with mem_ack |

## Verification
Two events can fall on the same clock edge. The last fill beat installs the tag, valid flag and final word at the same edge at which the controller returns to idle. In the very next cycle, the held request must match against that fresh state and, for a store, merge its word and set the dirty flag. The bench provokes this with store misses and load misses to lines whose old contents are dirty, sometimes on the last word of a line. It judges the outcome by the completion cycle of each request, by later loads of every word in the line, and by the data written back when the line is evicted again. Memory acknowledges each beat after a fixed delay, and every beat address and data word is compared against the bench's own record of the architected memory.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2
  } mstate_e;
endpackage

// File: rtl/dcache_tags.sv
module dcache_tags #(
  parameter int LINES = 64,
  parameter int IDX_W = 6,
  parameter int TAG_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             install,
  input  logic [IDX_W-1:0] inst_idx,
  input  logic [TAG_W-1:0] inst_tag,
  input  logic             mark_dirty,
  input  logic [IDX_W-1:0] dirty_idx
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (install) begin
      valid_q[inst_idx] <= 1'b1;
      dirty_q[inst_idx] <= 1'b0;
    end else if (mark_dirty) begin
      dirty_q[dirty_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (install) tag_q[inst_idx] <= inst_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/dcache_data.sv
module dcache_data #(
  parameter int LINES  = 64,
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  parameter int IDX_W  = 6,
  parameter int WSEL_W = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [WSEL_W-1:0] w_sel,
  input  logic [WORD_W-1:0] w_data,
  input  logic [IDX_W-1:0]  a_idx,
  input  logic [WSEL_W-1:0] a_sel,
  output logic [WORD_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  input  logic [WSEL_W-1:0] b_sel,
  output logic [WORD_W-1:0] b_data
);
  localparam int ENTRIES = LINES * WORDS;
  localparam int FLAT_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [WORD_W-1:0] arr [ENTRIES];

  function automatic logic [FLAT_W-1:0] flat(input logic [IDX_W-1:0] idx,
                                             input logic [WSEL_W-1:0] sel);
    return FLAT_W'(int'(idx) * WORDS + int'(sel));
  endfunction

  always_ff @(posedge clk) begin
    if (we) arr[flat(w_idx, w_sel)] <= w_data;
  end

  assign a_data = arr[flat(a_idx, a_sel)];
  assign b_data = arr[flat(b_idx, b_sel)];
endmodule

// File: rtl/dcache_miss_fsm.sv
module dcache_miss_fsm
  import dcache_pkg::*;
#(
  parameter int                IDX_W  = 6,
  parameter int                TAG_W  = 22,
  parameter int                WSEL_W = 2,
  parameter logic [WSEL_W-1:0] LAST   = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_dirty,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic [TAG_W-1:0]  start_tag,
  input  logic [TAG_W-1:0]  start_vtag,
  input  logic              mem_ack,
  output mstate_e           state,
  output logic [WSEL_W-1:0] beat,
  output logic [IDX_W-1:0]  m_idx,
  output logic [TAG_W-1:0]  m_tag,
  output logic [TAG_W-1:0]  v_tag,
  output logic              fill_beat,
  output logic              fill_done
);
  logic last_beat;
  assign last_beat = (beat == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      beat  <= '0;
      m_idx <= '0;
      m_tag <= '0;
      v_tag <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          m_idx <= start_idx;
          m_tag <= start_tag;
          v_tag <= start_vtag;
          beat  <= '0;
          state <= start_dirty ? ST_WBACK : ST_FILL;
        end
        ST_WBACK: if (mem_ack) begin
          if (last_beat) begin
            beat  <= '0;
            state <= ST_FILL;
          end else begin
            beat <= beat + 1'b1;
          end
        end
        ST_FILL: if (mem_ack) begin
          if (last_beat) begin
            beat  <= '0;
            state <= ST_IDLE;
          end else begin
            beat <= beat + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign fill_beat = (state == ST_FILL) && mem_ack;
  assign fill_done = fill_beat && last_beat;
endmodule

// File: rtl/dcache_wb.sv
module dcache_wb
  import dcache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int LINES  = 64,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam int BYTE_W    = $clog2(WORD_W / 8);
  localparam int WOFF_BITS = $clog2(WORDS);
  localparam int WSEL_W    = (WOFF_BITS > 0) ? WOFF_BITS : 1;
  localparam int IDX_W     = $clog2(LINES);
  localparam int IDX_LSB   = BYTE_W + WOFF_BITS;
  localparam int TAG_LSB   = IDX_LSB + IDX_W;
  localparam int TAG_W     = ADDR_W - TAG_LSB;
  localparam logic [WSEL_W-1:0] WSEL_MASK = WSEL_W'(WORDS - 1);

  // Address field arithmetic
  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return TAG_W'(a >> TAG_LSB);
  endfunction
  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return IDX_W'(a >> IDX_LSB);
  endfunction
  function automatic logic [WSEL_W-1:0] wsel_of(input logic [ADDR_W-1:0] a);
    return WSEL_W'(a >> BYTE_W) & WSEL_MASK;
  endfunction
  function automatic logic [ADDR_W-1:0] line_addr(input logic [TAG_W-1:0]  t,
                                                  input logic [IDX_W-1:0]  i,
                                                  input logic [WSEL_W-1:0] s);
    return (ADDR_W'(t) << TAG_LSB) | (ADDR_W'(i) << IDX_LSB) |
           (ADDR_W'(s & WSEL_MASK) << BYTE_W);
  endfunction

  // Named internal events
  mstate_e           state;
  logic [WSEL_W-1:0] beat;
  logic [IDX_W-1:0]  m_idx;
  logic [TAG_W-1:0]  m_tag, v_tag;
  logic              fill_beat, fill_done;
  logic              idle, tag_match, lookup_hit, miss_start, wr_hit;
  logic              line_valid, line_dirty;
  logic [TAG_W-1:0]  line_tag;
  logic [IDX_W-1:0]  look_idx;
  logic [TAG_W-1:0]  look_tag;
  logic [WSEL_W-1:0] look_sel;
  logic              dat_we;
  logic [IDX_W-1:0]  dat_idx;
  logic [WSEL_W-1:0] dat_sel;
  logic [WORD_W-1:0] dat_wdata, rd_a, rd_b;

  assign look_idx   = idx_of(cpu_addr);
  assign look_tag   = tag_of(cpu_addr);
  assign look_sel   = wsel_of(cpu_addr);
  assign idle       = (state == ST_IDLE);
  assign tag_match  = line_valid && (line_tag == look_tag);
  assign lookup_hit = idle && cpu_req && tag_match;
  assign miss_start = idle && cpu_req && !tag_match;
  assign wr_hit     = lookup_hit && cpu_we;

  dcache_tags #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(look_idx), .rd_valid(line_valid), .rd_dirty(line_dirty), .rd_tag(line_tag),
    .install(fill_done), .inst_idx(m_idx), .inst_tag(m_tag),
    .mark_dirty(wr_hit), .dirty_idx(look_idx)
  );

  assign dat_we    = wr_hit || fill_beat;
  assign dat_idx   = fill_beat ? m_idx : look_idx;
  assign dat_sel   = fill_beat ? beat : look_sel;
  assign dat_wdata = fill_beat ? mem_rdata : cpu_wdata;

  dcache_data #(.LINES(LINES), .WORDS(WORDS), .WORD_W(WORD_W),
                .IDX_W(IDX_W), .WSEL_W(WSEL_W)) u_data (
    .clk(clk), .we(dat_we), .w_idx(dat_idx), .w_sel(dat_sel), .w_data(dat_wdata),
    .a_idx(look_idx), .a_sel(look_sel), .a_data(rd_a),
    .b_idx(m_idx), .b_sel(beat), .b_data(rd_b)
  );

  dcache_miss_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W), .WSEL_W(WSEL_W),
                    .LAST(WSEL_MASK)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .start(miss_start), .start_dirty(line_valid && line_dirty),
    .start_idx(look_idx), .start_tag(look_tag), .start_vtag(line_tag),
    .mem_ack(mem_ack), .state(state), .beat(beat),
    .m_idx(m_idx), .m_tag(m_tag), .v_tag(v_tag),
    .fill_beat(fill_beat), .fill_done(fill_done)
  );

  assign cpu_ready  = lookup_hit;
  assign cpu_rvalid = lookup_hit && !cpu_we;
  assign cpu_rdata  = rd_a;
  assign mem_req    = !idle;
  assign mem_we     = (state == ST_WBACK);
  assign mem_addr   = mem_we ? line_addr(v_tag, m_idx, beat) : line_addr(m_tag, m_idx, beat);
  assign mem_wdata  = rd_b;
endmodule

// File: rtl/dcache_wb_chk.sv
module dcache_wb_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              miss_start,
  input logic              fill_done
);
  // R3
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> (cpu_req && !mem_req));

  // R9
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R5
  wb_before_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> !(mem_req && mem_we));

  // R10
  one_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_start |=> (mem_req && !cpu_ready));

  // R7
  fill_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> !mem_req);
endmodule

bind dcache_wb dcache_wb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .miss_start(miss_start), .fill_done(fill_done)
);

// File: tb/dcache_env.sv
module dcache_env #(
  parameter int LINES = 64,
  parameter int WORDS = 4,
  parameter int SCEN  = 0
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_cmp,
  output int   n_bad,
  output logic done
);
  localparam int LAT = 2;

  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready, cpu_rvalid;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  dcache_wb #(.ADDR_W(32), .WORD_W(32), .LINES(LINES), .WORDS(WORDS)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  logic [31:0] backing [logic [31:0]];
  logic [31:0] gold    [logic [31:0]];
  logic [31:0] wb_aq[$], wb_dq[$], rd_aq[$];
  bit          order_bad;
  int          wait_cnt;
  int          ref_tag [LINES];
  bit          ref_valid [LINES];
  bit          ref_dirty [LINES];

  function automatic logic [31:0] init_val(input logic [31:0] a);
    return a * 32'd7 + 32'h1357_0000;
  endfunction
  function automatic logic [31:0] mem_get(input logic [31:0] a);
    return backing.exists(a) ? backing[a] : init_val(a);
  endfunction
  function automatic logic [31:0] gold_get(input logic [31:0] a);
    return gold.exists(a) ? gold[a] : init_val(a);
  endfunction

  // Next-level memory: acknowledges each beat LAT cycles after it appears.
  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (rst_n && mem_req) begin
      if (wait_cnt == LAT) begin
        wait_cnt = 0;
        mem_ack  = 1'b1;
        if (mem_we) begin
          if (rd_aq.size() > 0) order_bad = 1'b1;
          wb_aq.push_back(mem_addr);
          wb_dq.push_back(mem_wdata);
          backing[mem_addr] = mem_wdata;
        end else begin
          rd_aq.push_back(mem_addr);
          mem_rdata = mem_get(mem_addr);
        end
      end else begin
        wait_cnt++;
      end
    end else begin
      wait_cnt = 0;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s (env %0d): actual %h expected %h", rq, SCEN, act, exp);
    end
  endtask

  // One processor access; exp_hit < 0 means use the bench's own line model.
  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                        input int exp_hit, input string rq);
    int   line, tg, n_wb, n_rd, waited;
    bit   mhit, exp;
    logic [31:0] old_base, new_base;
    line = int'((a / (4 * WORDS)) % LINES);
    tg   = int'(a / (4 * WORDS * LINES));
    mhit = ref_valid[line] && (ref_tag[line] == tg);
    exp  = (exp_hit >= 0) ? exp_hit[0] : mhit;
    n_wb = (!mhit && ref_valid[line] && ref_dirty[line]) ? WORDS : 0;
    n_rd = mhit ? 0 : WORDS;
    old_base = 32'(ref_tag[line] * 4 * WORDS * LINES + line * 4 * WORDS);
    new_base = a & ~32'(4 * WORDS - 1);
    wb_aq.delete(); wb_dq.delete(); rd_aq.delete(); order_bad = 0;

    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    #1;
    chk(cpu_ready == exp, {rq, " hit in first cycle"}, 32'(cpu_ready), 32'(exp));
    waited = 0;
    while (!cpu_ready) begin
      @(negedge clk); #1;
      waited++;
    end
    chk(mem_req == 1'b0, "R3 no memory traffic at completion", 32'(mem_req), 0);
    if (!we) begin
      chk(cpu_rvalid == 1'b1, "R3 rvalid on load", 32'(cpu_rvalid), 1);
      chk(cpu_rdata == gold_get(a), {rq, " load data"}, cpu_rdata, gold_get(a));
    end
    if (!exp) chk(waited > 0, "R10 miss stalls requester", 32'(waited), 1);
    @(posedge clk); #1;
    cpu_req = 1'b0;
    if (we) gold[a] = d;

    chk(wb_aq.size() == n_wb, n_wb > 0 ? "R5 write-back beats" : "R6 no write-back",
        32'(wb_aq.size()), 32'(n_wb));
    chk(rd_aq.size() == n_rd, mhit ? "R4 hit has no fill" : "R7 fill beats",
        32'(rd_aq.size()), 32'(n_rd));
    chk(!order_bad, "R5 write-back before fill", 32'(order_bad), 0);
    foreach (wb_aq[k]) begin
      chk(wb_aq[k] == old_base + 32'(4 * k), "R5 write-back address", wb_aq[k],
          old_base + 32'(4 * k));
      chk(wb_dq[k] == gold_get(wb_aq[k]), "R5 write-back data", wb_dq[k],
          gold_get(wb_aq[k]));
    end
    foreach (rd_aq[k])
      chk(rd_aq[k] == new_base + 32'(4 * k), "R7 fill address", rd_aq[k],
          new_base + 32'(4 * k));

    if (!mhit) ref_dirty[line] = we;
    else if (we) ref_dirty[line] = 1'b1;
    ref_valid[line] = 1'b1;
    ref_tag[line]   = tg;
  endtask

  initial begin
    int unsigned seed;
    n_cmp = 0; n_bad = 0; done = 1'b0; wait_cnt = 0; order_bad = 0;
    foreach (ref_valid[i]) begin ref_valid[i] = 0; ref_dirty[i] = 0; ref_tag[i] = 0; end
    @(posedge rst_n);
    @(negedge clk); #1;
    chk(cpu_ready == 1'b0, "R2 ready low after reset", 32'(cpu_ready), 0);
    chk(mem_req == 1'b0, "R2 mem_req low after reset", 32'(mem_req), 0);

    if (SCEN == 0) begin
      access(0, 32'd1200, 0, 0, "R2 first access misses");
      access(0, 32'd1204, 0, 1, "R3 hit same line");
      access(1, 32'd1204, 32'hCAFE_0001, 1, "R4 write hit");
      access(0, 32'd1204, 0, 1, "R4 read back store");
      access(0, 32'd1216, 0, 0, "R1 line 12 miss");
      access(0, 32'd1200, 0, 1, "R1 line 11 kept");
      access(0, 32'd2224, 0, 0, "R1 conflict evicts line 11");
      access(0, 32'd176, 0, 0, "R6 clean conflict");
      access(1, 32'd4104, 32'hBEEF_0002, 0, "R8 write miss");
      access(0, 32'd4096, 0, 1, "R8 fetched word 0");
      access(0, 32'd4100, 0, 1, "R8 fetched word 1");
      access(0, 32'd4104, 0, 1, "R8 merged word");
      access(0, 32'd4108, 0, 1, "R8 fetched word 3");
      access(0, 32'd5128, 0, 0, "R8 dirty merged line evicted");
      access(1, 32'd236, 32'h1111_2222, 0, "R8 store miss last word");
      access(0, 32'd1260, 0, 0, "R5 eviction right after merge");
      seed = 32'd12345;
      for (int n = 0; n < 80; n++) begin
        logic [31:0] a;
        seed = seed * 32'd1103515245 + 32'd12345;
        a = 32'((seed >> 8) % 3) * 1024 + 32'(((seed >> 12) % 3) * 29 % 64) * 16 +
            32'((seed >> 16) % 4) * 4;
        access(seed[20], a, seed ^ 32'h0F0F_0F0F, -1, "R7 mixed traffic");
      end
    end else begin
      int wseq [9] = '{22, 26, 22, 26, 16, 3, 16, 18, 16};
      int hseq [9] = '{0, 0, 1, 1, 0, 0, 1, 0, 1};
      for (int n = 0; n < 9; n++)
        access(0, 32'(wseq[n] * 4), 0, hseq[n], "R11 sequence");
      access(0, 32'd64, 0, 1, "R11 line 0 tag 10");
      access(0, 32'd72, 0, 1, "R11 line 2 tag 10");
      access(0, 32'd12, 0, 1, "R11 line 3 tag 00");
      access(0, 32'd88, 0, 1, "R11 line 6 tag 10");
    end
    done = 1'b1;
  end
endmodule

// File: tb/dcache_wb_test.sv
`timescale 1ns/1ps
module dcache_wb_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   cmp_big, bad_big, cmp_small, bad_small;
  logic done_big, done_small;
  bit   finished = 0;

  always #2 clk = ~clk;

  dcache_env #(.LINES(64), .WORDS(4), .SCEN(0)) uut (
    .clk(clk), .rst_n(rst_n), .n_cmp(cmp_big), .n_bad(bad_big), .done(done_big));
  dcache_env #(.LINES(8), .WORDS(1), .SCEN(1)) uut_small (
    .clk(clk), .rst_n(rst_n), .n_cmp(cmp_small), .n_bad(bad_small), .done(done_small));

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    wait (done_big === 1'b1 && done_small === 1'b1);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***",
               cmp_big + cmp_small, bad_big + bad_small);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***",
               cmp_big + cmp_small + 1, bad_big + bad_small + 1);
      $finish;
    end
  end
endmodule